// File: doc/BRIEF.md
# Mixed-Radix Final Stage for a Power-of-Two Residue

This block is the last step of a residue-to-binary converter for a five-modulus residue system with moduli 2^n, 2^(2n+1)-1, 2^n+1, 2^(n/2)+1 and 2^(n/2)-1, where n is even. An earlier stage combines the four odd residues. It hands over two quantities. The first is `y_i`, the combined value of the three small moduli, whose product is 2^(2n)-1. The second is `x1_i`, the residue modulo 2^(2n+1)-1. Together they define Z = x1 + (2^(2n+1)-1)·Y, which lies in the range 0 to P-1, where P = (2^(2n)-1)(2^(2n+1)-1).

The stage merges Z with the power-of-two residue `x5_i` and returns the full binary number X in the range 0 to 2^n·P-1. It uses one mixed-radix step, X = Z + v·P. The inverse of P modulo 2^n is 1, so the digit v needs no multiplier: v = (x5 - Z) mod 2^n. This value depends only on the low n bits of `x5_i`, `x1_i` and `y_i`. The product v·P is expanded into shifted copies of v, and these are summed in a carry-save tree together with the concatenation {v, Y, x1}. The stage is purely combinational.

Top module: `mrc_final_stage`

## Requirements
- R1: For valid inputs, `x_o` equals the unique X in the range 0 to 2^N·P-1 that satisfies two conditions: X mod 2^N = `x5_i`, and X mod P = `x1_i` + (2^(2N+1)-1)·`y_i`. Here P = (2^(2N)-1)(2^(2N+1)-1).
- R2: The stage holds no state. `x_o` reflects the present inputs within the same clock cycle in which they are applied.
- R3: Bits N-1..0 of `x_o` always equal `x5_i`.
- R4: The high digit floor(`x_o`/P) equals (`x5_i` - `x1_i` + `y_i`) mod 2^N. Only bits N-1..0 of `x1_i` and `y_i` enter this digit.
- R5: All-zero inputs give `x_o` = 0. The inputs that encode 2^N·P-1 give `x_o` = 2^N·P-1. Those inputs are `x5_i` all ones, `y_i` = 2^(2N)-2 and `x1_i` = 2^(2N+1)-2.
- R6: Inputs are valid when `y_i` is at most 2^(2N)-2 and `x1_i` is at most 2^(2N+1)-2. For valid inputs, `x_o` is below 2^N·P, and any carry beyond bit 5N is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| y_i | input | 2N | combined value of the three small moduli, 0 to 2^(2N)-2 |
| x1_i | input | 2N+1 | residue modulo 2^(2N+1)-1 |
| x5_i | input | N | residue modulo 2^N |
| x_o | output | 5N+1 | reconstructed binary value |

## Verification
Every result of this block is combinational, so each one is due in the same cycle as the stimulus that produces it. No result is pipelined. The bench therefore applies a new input set just after a rising edge and samples `x_o` at the following falling edge. This leaves half a period for the adder tree to settle and puts the check away from any edge. The bench drives two copies of the stage. A configuration with N=2 is swept over every value of its dynamic range. A configuration with N=4 is swept along a stride that covers every value of `x5_i`, together with the corner values 0, P-1, P and 2^N·P-1.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
    // Width of the reconstructed value for even n
    function automatic int unsigned out_width(input int unsigned n);
        return 5 * n + 1;
    endfunction

    // Correction for two one's-complemented subtrahends in the final sum
    localparam int unsigned SUB_CORR = 2;
endpackage

// File: rtl/mrc_csa.sv
module mrc_csa #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] carry_o   // already weighted by 2, MSB carry dropped
);
    logic [WIDTH-1:0] maj;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
        assign maj[i]   = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
    end

    assign carry_o = {maj[WIDTH-2:0], 1'b0};

    logic [WIDTH-1:0] in_total;
    logic [WIDTH-1:0] out_total;
    always_comb begin
        in_total  = a_i + b_i + c_i;
        out_total = sum_o + carry_o;
        AST_CSA_CONSERVES: assert (in_total == out_total); // R1
    end
endmodule

// File: rtl/mrc_digit.sv
module mrc_digit #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] x5_i,
    input  logic [N-1:0] x1_lo_i,
    input  logic [N-1:0] y_lo_i,
    output logic [N-1:0] v_o
);
    logic [N-1:0] s;
    logic [N-1:0] c;

    // v = x5 - x1 + y (mod 2^N): one inverted subtrahend, +1 as carry-in
    mrc_csa #(.WIDTH(N)) u_csa (
        .a_i    (x5_i),
        .b_i    (~x1_lo_i),
        .c_i    (y_lo_i),
        .sum_o  (s),
        .carry_o(c)
    );

    assign v_o = s + c + N'(1);

    logic [N-1:0] residue_gap;
    always_comb begin
        residue_gap = v_o + x1_lo_i - y_lo_i - x5_i;
        AST_DIGIT_CONGRUENT: assert (residue_gap == '0); // R4
    end
endmodule

// File: rtl/mrc_final_stage.sv
module mrc_final_stage #(
    parameter int unsigned N = 4
) (
    input  logic [2*N-1:0]                     y_i,
    input  logic [2*N:0]                       x1_i,
    input  logic [N-1:0]                       x5_i,
    output logic [mrc_pkg::out_width(N)-1:0]   x_o
);
    localparam int unsigned W = mrc_pkg::out_width(N);

    localparam logic [W:0] ONE       = (W+1)'(1);
    localparam logic [W:0] MOD_SMALL = (ONE << (2*N)) - ONE;
    localparam logic [W:0] MOD_BIG   = (ONE << (2*N+1)) - ONE;
    localparam logic [W:0] DYN_RANGE = (MOD_SMALL * MOD_BIG) << N;

    typedef struct packed {
        logic [W-1:0] h1;   // {v, Y, x1}
        logic [W-1:0] h2;   // ~{v, Y}
        logic [W-1:0] h3;   // ~(v << 2N+1)
        logic [W-1:0] h4;   // v
    } terms_t;

    logic [N-1:0] v;
    terms_t       terms;
    logic [W-1:0] s1, c1, s2, c2;

    mrc_digit #(.N(N)) u_digit (
        .x5_i   (x5_i),
        .x1_lo_i(x1_i[N-1:0]),
        .y_lo_i (y_i[N-1:0]),
        .v_o    (v)
    );

    // X = {v,Y,x1} - {v,Y} - (v << 2N+1) + v
    always_comb begin
        terms.h1 = {v, y_i, x1_i};
        terms.h2 = ~{{(2*N+1){1'b0}}, v, y_i};
        terms.h3 = ~{{(2*N){1'b0}}, v, {(2*N+1){1'b0}}};
        terms.h4 = {{(4*N+1){1'b0}}, v};
    end

    mrc_csa #(.WIDTH(W)) u_csa_a (
        .a_i(terms.h1), .b_i(terms.h2), .c_i(terms.h3),
        .sum_o(s1), .carry_o(c1)
    );

    mrc_csa #(.WIDTH(W)) u_csa_b (
        .a_i(s1), .b_i(c1), .c_i(terms.h4),
        .sum_o(s2), .carry_o(c2)
    );

    assign x_o = s2 + c2 + W'(mrc_pkg::SUB_CORR);

    logic inputs_valid;
    always_comb begin
        inputs_valid = (y_i != '1) && (x1_i != '1);
        AST_LOW_DIGIT: assert (x_o[N-1:0] == x5_i); // R3
        AST_IN_RANGE: assert (!inputs_valid || ({1'b0, x_o} < DYN_RANGE)); // R6
        AST_ZERO_MAPS_ZERO: assert (!((y_i == '0) && (x1_i == '0) && (x5_i == '0)) || (x_o == '0)); // R5
    end
endmodule

// File: tb/mrc_final_stage_bench.sv
module mrc_final_stage_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    // N = 4 instance
    logic [7:0]  y_b  = '0;
    logic [8:0]  x1_b = '0;
    logic [3:0]  x5_b = '0;
    logic [20:0] x_b;
    // N = 2 instance
    logic [3:0]  y_s  = '0;
    logic [4:0]  x1_s = '0;
    logic [1:0]  x5_s = '0;
    logic [10:0] x_s;

    mrc_final_stage #(.N(4)) u_mrc_final_stage (
        .y_i(y_b), .x1_i(x1_b), .x5_i(x5_b), .x_o(x_b)
    );
    mrc_final_stage #(.N(2)) u_mrc_final_stage_small (
        .y_i(y_s), .x1_i(x1_s), .x5_i(x5_s), .x_o(x_s)
    );

    localparam longint PB_BIG = 511;
    localparam longint P_BIG  = 255 * 511;
    localparam longint DR_BIG = 16 * P_BIG;
    localparam longint PB_SM  = 31;
    localparam longint P_SM   = 15 * 31;
    localparam longint DR_SM  = 4 * P_SM;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_big(input longint xv);
        longint z;
        z    = xv % P_BIG;
        x5_b = 4'(xv % 16);
        x1_b = 9'(z % PB_BIG);
        y_b  = 8'(z / PB_BIG);
    endtask

    task automatic load_small(input longint xv);
        longint z;
        z    = xv % P_SM;
        x5_s = 2'(xv % 4);
        x1_s = 5'(z % PB_SM);
        y_s  = 4'(z / PB_SM);
    endtask

    initial begin
        longint xv;
        longint xs;
        longint dig;
        // Idle phase: all-zero inputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 zero big", longint'(x_b), 0);
        chk("R5 zero small", longint'(x_s), 0);

        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            case (i)
                0: xv = DR_BIG - 1;
                1: xv = P_BIG - 1;
                2: xv = P_BIG;
                3: xv = 0;
                default: xv = (longint'(i) * 104729 + 13) % DR_BIG;
            endcase
            xs = longint'(i) % DR_SM;
            load_big(xv);
            load_small(xs);
            @(negedge clk);
            // Result due in the same cycle (R2)
            chk("R1 R2 big", longint'(x_b), xv);
            chk("R1 R2 small", longint'(x_s), xs);
            chk("R3 low bits", longint'(x_b[3:0]), longint'(x5_b));
            dig = (longint'(x5_b) - longint'(x1_b[3:0]) + longint'(y_b[3:0]) + 32) % 16;
            chk("R4 high digit", longint'(x_b) / P_BIG, dig);
            chk("R6 range", longint'(longint'(x_b) < DR_BIG), 1);
            if (i == 0) chk("R5 top corner", longint'(x_b), DR_BIG - 1);
            if (xs == DR_SM - 1) chk("R5 top corner small", longint'(x_s), DR_SM - 1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule